// File: doc/BRIEF.md
# Prioritized Microtask Switching Sequencer

This block chooses which of sixteen hardware tasks owns a shared micromachine and forms the control-store address for every cycle. Each microinstruction carries a full successor address rather than relying on an incrementing counter. A conditional branch ORs condition bits into that address. Because fetch is pipelined, the condition bits that arrive with one instruction change the address taken by the instruction that follows it.

A 16-entry table holds, for each task, the address where that task will resume. A task gives up the machine by raising the task strobe. The next-task register then loads the highest-priority pending wakeup. One more instruction of the old task executes before the new task's saved address is fetched. Because the table preserves every task's place, a switch costs no extra cycles. The current-task number is exported so that device logic can decode task-specific functions. The control store is an external synchronous memory addressed by `fetch_addr`. The instruction it returns drives `task_strobe`, `next_field` and `branch_or` in the following cycle.

Top module: `utask_sequencer`

## Requirements
- R1: Under reset, `cur_task` and `nxt_task` are 0, `fetch_addr` is 0, and every saved table entry is cleared, so the first switch to any task fetches address 0.
- R2: When a switch to task t takes effect, `fetch_addr` equals the successor address that task t saved in the last cycle it executed, including any branch bits merged into that successor.
- R3: While `nxt_task` equals `cur_task`, `fetch_addr` is `next_field` ORed with the pending branch bits, and this value is saved as the current task's table entry at the clock edge.
- R4: `branch_or` bits presented with one instruction are ORed into the `next_field` of the following instruction of the same task. They never change the address produced in their own cycle.
- R5: When `task_strobe` is high, `nxt_task` loads at the clock edge the index of the highest-numbered asserted `wake_req` line, where a larger index means higher priority and line 0 is treated as always asserted.
- R6: In the cycle after a switching strobe, `cur_task` still shows the old task and `fetch_addr` is the new task's saved entry. `cur_task` changes to the new task at the following edge.
- R7: Without `task_strobe`, `nxt_task` holds its value whatever `wake_req` does, and `cur_task` copies `nxt_task` at every edge.
- R8: In the first cycle after reset is released, `task_strobe`, `next_field` and `branch_or` are ignored: `fetch_addr` is 0 and `nxt_task` stays 0.
- R9: A strobe with no `wake_req` line above 0 asserted loads `nxt_task` with 0.
- R10: In a switch cycle, the `branch_or` bits are discarded, while the bits pending from the strobing instruction are merged into the old task's saved entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | NUM_TASKS | Per-task service request lines, index = priority |
| task_strobe | input | 1 | Executing instruction relinquishes the machine |
| next_field | input | ADDR_W | Successor address field of the executing instruction |
| branch_or | input | ADDR_W | Condition bits to OR into the following successor |
| cur_task | output | TASK_W | Task owning the executing instruction |
| nxt_task | output | TASK_W | Task that owns the next fetched instruction |
| fetch_addr | output | ADDR_W | Control-store address for the next instruction |

## Verification
A corrupted table entry does not show up while its task is dormant. It appears at `fetch_addr` in the single cycle when that task is resumed, so scenarios must resume several tasks after other tasks have written the table. A wrong pending-branch register changes `fetch_addr` one instruction after the bits were presented, and across a switch it shows up when the old task returns. A faulty priority choice shows on `nxt_task` at the edge right after the strobe and on `cur_task` one cycle later.

// File: rtl/utsq_pkg.sv
package utsq_pkg;
  // Sequencer phase: the first cycle after reset has no valid instruction.
  typedef enum logic {
    PH_START = 1'b0,
    PH_RUN   = 1'b1
  } seq_phase_e;
endpackage

// File: rtl/utsq_prio_pick.sv
module utsq_prio_pick #(
  parameter int NT = 16,
  parameter int TW = 4
) (
  input  logic [NT-1:0] req,
  output logic [TW-1:0] win
);
  // Ascending scan: the highest set index is the last to be assigned.
  always_comb begin
    win = '0;
    for (int i = 0; i < NT; i++) begin
      if (req[i]) win = TW'(i);
    end
  end
endmodule

// File: rtl/utsq_pc_table.sv
module utsq_pc_table #(
  parameter int NT = 16,
  parameter int TW = 4,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [TW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [TW-1:0] raddr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] mem [NT];

  // Small table: cleared under reset and read asynchronously (LUT RAM).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/utsq_branch_merge.sv
module utsq_branch_merge #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] br_in,
  input  logic [AW-1:0] field_in,
  output logic [AW-1:0] succ
);
  logic [AW-1:0] pend_q;

  // Condition bits wait one instruction before reaching an address.
  always_ff @(posedge clk) begin
    if (rst || !capture) pend_q <= '0;
    else                 pend_q <= br_in;
  end

  assign succ = field_in | pend_q;
endmodule

// File: rtl/utask_sequencer.sv
module utask_sequencer #(
  parameter int NUM_TASKS = 16,
  parameter int ADDR_W    = 10,
  localparam int TASK_W   = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TASKS-1:0] wake_req,
  input  logic                 task_strobe,
  input  logic [ADDR_W-1:0]    next_field,
  input  logic [ADDR_W-1:0]    branch_or,
  output logic [TASK_W-1:0]    cur_task,
  output logic [TASK_W-1:0]    nxt_task,
  output logic [ADDR_W-1:0]    fetch_addr
);
  import utsq_pkg::*;

  seq_phase_e         phase_q;
  logic               running;
  logic               switching;
  logic [NUM_TASKS-1:0] req_all;
  logic [TASK_W-1:0]  winner;
  logic [ADDR_W-1:0]  succ;
  logic [ADDR_W-1:0]  saved_pc;

  assign running   = (phase_q == PH_RUN);
  assign switching = (nxt_task != cur_task);
  // Task 0 is always requesting.
  assign req_all   = wake_req | NUM_TASKS'(1);

  utsq_prio_pick #(.NT(NUM_TASKS), .TW(TASK_W)) pick_i (
    .req (req_all),
    .win (winner)
  );

  utsq_branch_merge #(.AW(ADDR_W)) merge_i (
    .clk      (clk),
    .rst      (rst),
    .capture  (running && !switching),
    .br_in    (branch_or),
    .field_in (next_field),
    .succ     (succ)
  );

  utsq_pc_table #(.NT(NUM_TASKS), .TW(TASK_W), .AW(ADDR_W)) table_i (
    .clk   (clk),
    .rst   (rst),
    .we    (running),
    .waddr (cur_task),
    .wdata (succ),
    .raddr (nxt_task),
    .rdata (saved_pc)
  );

  // Same task continues: take the merged successor directly.
  // Switch pending or start-up: resume from the saved entry.
  assign fetch_addr = (running && !switching) ? succ : saved_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_START;
      cur_task <= '0;
      nxt_task <= '0;
    end else begin
      phase_q  <= PH_RUN;
      cur_task <= nxt_task;
      if (running && task_strobe) nxt_task <= winner;
    end
  end

  // R7: the current task trails the next-task register by one edge.
  assert_cur_follows_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cur_task == $past(nxt_task));

  // R7: no strobe, no change of the next task.
  assert_hold_next_R7: assert property (@(posedge clk) disable iff (rst)
    !task_strobe |=> $stable(nxt_task));

  // R5: the chosen task is requesting and nothing above it is.
  assert_prio_pick_R5: assert property (@(posedge clk) disable iff (rst)
    (running && task_strobe) |=>
      ((($past(wake_req) | NUM_TASKS'(1)) >> nxt_task) == NUM_TASKS'(1)));

  // R9: only the emulator requesting gives task 0.
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (running && task_strobe && (wake_req[NUM_TASKS-1:1] == '0)) |=> nxt_task == '0);

  // R8: start-up cycle fetches address 0 and ignores the strobe.
  assert_start_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !running |-> (fetch_addr == '0 && nxt_task == '0));
endmodule

// File: tb/utask_sequencer_tb_top.sv
module utask_sequencer_tb_top;
  localparam int NT = 16;
  localparam int AW = 10;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NT-1:0] wake_req = '0;
  logic          task_strobe = 1'b0;
  logic [AW-1:0] next_field = '0;
  logic [AW-1:0] branch_or = '0;
  logic [TW-1:0] cur_task;
  logic [TW-1:0] nxt_task;
  logic [AW-1:0] fetch_addr;

  always #4 clk = ~clk;

  utask_sequencer #(.NUM_TASKS(NT), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wake_req(wake_req), .task_strobe(task_strobe),
    .next_field(next_field), .branch_or(branch_or),
    .cur_task(cur_task), .nxt_task(nxt_task), .fetch_addr(fetch_addr)
  );

  typedef struct {
    logic [TW-1:0] ct;
    logic [TW-1:0] nt;
    logic [AW-1:0] fa;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Reference model state, built from the requirements.
  logic [AW-1:0] m_pc [NT];
  logic [TW-1:0] m_ct, m_nt;
  logic [AW-1:0] m_br;
  bit            m_run;

  function automatic logic [TW-1:0] top_req(input logic [NT-1:0] w);
    logic [TW-1:0] r = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (w[i] || i == 0) begin
        r = TW'(i);
        break;
      end
    end
    return r;
  endfunction

  // Driver: applies one instruction, records the expectation, advances the model.
  task automatic step(input logic [NT-1:0] w, input logic t,
                      input logic [AW-1:0] n, input logic [AW-1:0] b,
                      input string tag);
    exp_t e;
    logic [AW-1:0] s;
    wake_req = w; task_strobe = t; next_field = n; branch_or = b;
    s = n | m_br;
    e.ct = m_ct; e.nt = m_nt; e.tag = tag;
    e.fa = (m_run && m_nt == m_ct) ? s : m_pc[m_nt];
    exp_q.push_back(e);
    if (m_run) begin
      m_pc[m_ct] = s;
      m_br = (m_nt != m_ct) ? '0 : b;
      m_ct = m_nt;
      if (t) m_nt = top_req(w);
    end else begin
      m_br = '0;
    end
    m_run = 1;
    @(negedge clk);
  endtask

  // Monitor: compares each cycle away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (cur_task !== e.ct || nxt_task !== e.nt || fetch_addr !== e.fa) begin
          fails++;
          $display("FAIL %s: got cur=%0d nxt=%0d fetch=%h, expected cur=%0d nxt=%0d fetch=%h",
                   e.tag, cur_task, nxt_task, fetch_addr, e.ct, e.nt, e.fa);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) m_pc[i] = '0;
    m_ct = '0; m_nt = '0; m_br = '0; m_run = 0;
    repeat (3) @(negedge clk);
    #2;
    checks++;  // R1 reset state
    if (cur_task !== '0 || nxt_task !== '0 || fetch_addr !== '0) begin
      fails++;
      $display("FAIL R1: got cur=%0d nxt=%0d fetch=%h, expected 0 0 000",
               cur_task, nxt_task, fetch_addr);
    end
    @(negedge clk);
    rst = 1'b0;
    step(16'hFFFF, 1'b1, 10'h3FF, 10'h3FF, "R8");    // start-up cycle ignored
    step(16'h0000, 1'b0, 10'h005, 10'h000, "R3");    // plain successor
    step(16'h0000, 1'b0, 10'h008, 10'h003, "R4");    // bits not applied to own address
    step(16'h0000, 1'b0, 10'h010, 10'h000, "R4");    // bits merged one later
    step(16'h0020, 1'b1, 10'h020, 10'h000, "R5");    // request task 5
    step(16'h0020, 1'b0, 10'h040, 10'h007, "R6");    // switch cycle, R10 bits dropped
    step(16'h0200, 1'b0, 10'h030, 10'h000, "R7");    // wake without strobe, R10 none pending
    step(16'h0000, 1'b0, 10'h031, 10'h000, "R7");
    step(16'h0000, 1'b1, 10'h050, 10'h002, "R9");    // nobody else requesting
    step(16'h0000, 1'b0, 10'h060, 10'h000, "R10");   // task 5 saves 0x62, resume task 0
    step(16'h00A0, 1'b1, 10'h041, 10'h000, "R5");    // 7 beats 5
    step(16'h0000, 1'b0, 10'h042, 10'h000, "R1");    // fresh task 7 starts at 0
    step(16'h0020, 1'b1, 10'h070, 10'h000, "R5");
    step(16'h0000, 1'b0, 10'h071, 10'h000, "R2");    // task 5 resumes at 0x62
    step(16'h0000, 1'b0, 10'h063, 10'h000, "R2");
    for (int k = 0; k < 400; k++) begin
      logic [NT-1:0] w;
      logic [AW-1:0] n, b;
      logic t;
      w = NT'($urandom) & NT'($urandom);
      t = ($urandom % 4) == 0;
      n = AW'($urandom);
      b = (($urandom % 3) == 0) ? AW'($urandom % 8) : '0;
      step(w, t, n, b, "R2");
    end
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule